// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for a precision time protocol clock. On every cycle of the datapath clock it adds a programmable fixed-point increment. The increment has an 8-bit whole-nanosecond part and a 32-bit fraction. The fraction builds up in a hidden 32-bit accumulator. When that accumulator overflows, one more nanosecond is added on that cycle. Because 64 bits of nanoseconds cover centuries, no separate cycle counter is kept.

Software reaches the block through a 32-bit register bus with a valid/ready request channel and a one-cycle read response. Several values are wider than one word, and the block keeps those accesses coherent in three ways:
- Reading the low time word captures the upper half at the same instant, and a later read of the high word returns that captured half.
- A time load is staged in the low word and takes effect only when the high word is written.
- A new increment is staged the same way and takes effect only when its high word is written.

The counter runs only while two separate enable registers are both set. A link-speed pulse loads a default increment from a small lookup. The lowest speed selects a zero increment, which stops the clock.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the block is in this state:
  - the time is 0;
  - the active increment is 0x01_9999_9999 (integer 0x01, fraction 0x9999_9999);
  - both enable bits are clear;
  - no response is pending, so `rsp_valid` is 0 and `req_ready` is 1.
- R2: While both enables are set and no time load commits, each cycle adds the active increment. The fraction is added into a 32-bit accumulator, and the time grows by the integer part plus that addition's carry. After a load of value V, therefore, k running cycles later the time equals V + floor(k * inc / 2^32), where inc = integer * 2^32 + fraction.
- R3: Word 0 holds enable A in bit 0 and word 1 holds enable B in bit 0. If either bit is clear, the time holds its value.
- R4: A write to word 2 stages the low 32 bits of a new time. A write to word 3 loads {written data, staged low} into the time at that cycle's edge. The load overrides that cycle's increment and clears the fraction accumulator.
- R5: A read of word 2 returns the low 32 bits of the time in the accepting cycle and captures the upper 32 bits of that same value. A read of word 3 returns the captured upper half, even if the live time has moved on since.
- R6: A write to word 4 stages the increment fraction. A write to word 5 commits {written data bits [7:0], staged fraction} as the active increment. Until that commit the old increment stays in use. Reads of word 4 return the active fraction, and reads of word 5 return the active integer part, zero-extended.
- R7: A pulse on `link_apply` loads the active increment from `link_speed`:
  - code 0 (no link or the fastest speed) loads 0x01_9999_9999, about 1.6 ns;
  - code 1 (10G) loads 0x03_3333_3333, about 3.2 ns;
  - code 2 (1G) loads 0x20_0000_0000, 32 ns;
  - code 3 (100M) loads 0, which stops the clock.
- R8: When an increment commit through word 5 and a `link_apply` pulse fall in the same cycle, the register commit wins.
- R9: An accepted read raises `rsp_valid` for exactly one cycle on the next cycle, with the read data on `rsp_rdata`. While `rsp_valid` is high, `req_ready` is low. Writes produce no response.
- R10: Reads of word 0 and word 1 return the matching enable bit in bit 0, with zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| link_apply | input | 1 | Pulse: load the default increment for `link_speed` |
| link_speed | input | 2 | Link speed code (0 fastest or none, 1 10G, 2 1G, 3 100M) |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The collision that matters most is a time load committing while the counter is running. On that edge the loaded value must appear alone, with no increment added on top. The bench provokes this on every load by leaving both enables set, checks the time on the cycle right after the load, and then checks the closed-form value after a random number of cycles. A second collision is an increment commit in the same cycle as a link-speed pulse. It is driven directly, and the winner is judged by reading back the active increment.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int TIME_W = 64;
    localparam int WORD_W = 32;
    localparam int FRAC_W = 32;
    localparam int INT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int SPD_W  = 2;
    localparam int INC_W  = INT_W + FRAC_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL_A  = 3'd0,
        RA_CTRL_B  = 3'd1,
        RA_TIME_LO = 3'd2,
        RA_TIME_HI = 3'd3,
        RA_INC_LO  = 3'd4,
        RA_INC_HI  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } inc_t;

    typedef struct packed {
        logic              load;
        logic [TIME_W-1:0] value;
    } time_load_t;

    typedef struct packed {
        logic valid;
        inc_t value;
    } inc_write_t;

    function automatic inc_t default_inc(input logic [SPD_W-1:0] spd);
        inc_t r;
        case (spd)
            2'd1:    r = '{whole: 8'h03, frac: 32'h3333_3333};
            2'd2:    r = '{whole: 8'h20, frac: 32'h0000_0000};
            2'd3:    r = '{whole: 8'h00, frac: 32'h0000_0000};
            default: r = '{whole: 8'h01, frac: 32'h9999_9999};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ptp_reg_if.sv
module ptp_reg_if
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic [TIME_W-1:0] time_now,
    input  inc_t              inc_active,
    output time_load_t        time_load,
    output inc_write_t        inc_write,
    output logic              run_en
);

    localparam int HI_W = TIME_W - WORD_W;

    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_data_q;
    logic              en_a_q, en_b_q;
    logic [WORD_W-1:0] time_lo_stage_q;
    logic [FRAC_W-1:0] inc_lo_stage_q;
    logic [HI_W-1:0]   shadow_hi_q;
    logic              acc, wr_acc, rd_acc;
    logic [WORD_W-1:0] rd_word;

    assign req_ready = !rsp_valid_q;
    assign acc       = req_valid && req_ready;
    assign wr_acc    = acc && req_write;
    assign rd_acc    = acc && !req_write;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_data_q;
    assign run_en    = en_a_q && en_b_q;

    always_comb begin
        time_load.load  = wr_acc && (req_addr == RA_TIME_HI);
        time_load.value = {req_wdata[HI_W-1:0], time_lo_stage_q};
        inc_write.valid = wr_acc && (req_addr == RA_INC_HI);
        inc_write.value = '{whole: req_wdata[INT_W-1:0], frac: inc_lo_stage_q};
    end

    always_comb begin
        rd_word = '0;
        case (req_addr)
            RA_CTRL_A:  rd_word[0] = en_a_q;
            RA_CTRL_B:  rd_word[0] = en_b_q;
            RA_TIME_LO: rd_word = time_now[WORD_W-1:0];
            RA_TIME_HI: rd_word = WORD_W'(shadow_hi_q);
            RA_INC_LO:  rd_word = WORD_W'(inc_active.frac);
            RA_INC_HI:  rd_word = WORD_W'(inc_active.whole);
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q     <= 1'b0;
            rsp_data_q      <= '0;
            en_a_q          <= 1'b0;
            en_b_q          <= 1'b0;
            time_lo_stage_q <= '0;
            inc_lo_stage_q  <= '0;
            shadow_hi_q     <= '0;
        end else begin
            rsp_valid_q <= rd_acc;
            if (rd_acc) begin
                rsp_data_q <= rd_word;
                if (req_addr == RA_TIME_LO) begin
                    shadow_hi_q <= time_now[TIME_W-1:WORD_W];
                end
            end
            if (wr_acc) begin
                case (req_addr)
                    RA_CTRL_A:  en_a_q          <= req_wdata[0];
                    RA_CTRL_B:  en_b_q          <= req_wdata[0];
                    RA_TIME_LO: time_lo_stage_q <= req_wdata;
                    RA_INC_LO:  inc_lo_stage_q  <= req_wdata[FRAC_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ptp_inc_sel.sv
module ptp_inc_sel
    import ptp_tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  inc_write_t       inc_write,
    input  logic             link_apply,
    input  logic [SPD_W-1:0] link_speed,
    output inc_t             inc_active
);

    inc_t inc_q;

    assign inc_active = inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q <= default_inc(2'd0);
        end else if (inc_write.valid) begin
            inc_q <= inc_write.value;
        end else if (link_apply) begin
            inc_q <= default_inc(link_speed);
        end
    end

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  inc_t              inc_active,
    input  time_load_t        time_load,
    output logic [TIME_W-1:0] time_now
);

    logic [TIME_W-1:0] time_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W-1:0] frac_sum;
    logic              carry;
    logic [TIME_W-1:0] step;

    assign time_now = time_q;

    always_comb begin
        {carry, frac_sum} = {1'b0, frac_q} + {1'b0, inc_active.frac};
        step = TIME_W'(inc_active.whole) + TIME_W'(carry);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
            frac_q <= '0;
        end else if (time_load.load) begin
            time_q <= time_load.value;
            frac_q <= '0;
        end else if (run_en) begin
            time_q <= time_q + step;
            frac_q <= frac_sum;
        end
    end

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              link_apply,
    input  logic [SPD_W-1:0]  link_speed,
    output logic [TIME_W-1:0] time_ns
);

    time_load_t time_load;
    inc_write_t inc_write;
    inc_t       inc_active;
    logic       run_en;

    ptp_reg_if u_reg (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .time_now   (time_ns),
        .inc_active (inc_active),
        .time_load  (time_load),
        .inc_write  (inc_write),
        .run_en     (run_en)
    );

    ptp_inc_sel u_inc (
        .clk        (clk),
        .rst        (rst),
        .inc_write  (inc_write),
        .link_apply (link_apply),
        .link_speed (link_speed),
        .inc_active (inc_active)
    );

    ptp_time_core u_core (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .inc_active (inc_active),
        .time_load  (time_load),
        .time_now   (time_ns)
    );

endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
    import ptp_tod_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [WORD_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              link_apply,
    input logic [SPD_W-1:0]  link_speed,
    input logic [TIME_W-1:0] time_ns,
    input logic              run_en,
    input inc_t              inc_active
);

    logic acc_rd, wr_time_hi, wr_inc_hi;
    assign acc_rd     = req_valid && req_ready && !req_write;
    assign wr_time_hi = req_valid && req_ready && req_write && (req_addr == RA_TIME_HI);
    assign wr_inc_hi  = req_valid && req_ready && req_write && (req_addr == RA_INC_HI);

    // R4
    time_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_time_hi |=> time_ns[TIME_W-1:WORD_W] == $past(req_wdata));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_time_hi) |=> $stable(time_ns));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !wr_time_hi) |=>
        (time_ns - $past(time_ns) - TIME_W'($past(inc_active.whole))) <= TIME_W'(1));

    // R9
    rsp_on_chk: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid);

    // R9
    rsp_off_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> !rsp_valid);

    // R7
    link_load_chk: assert property (@(posedge clk) disable iff (rst)
        (link_apply && !wr_inc_hi) |=> inc_active == default_inc($past(link_speed)));

endmodule

bind ptp_tod_counter ptp_tod_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .link_apply (link_apply),
    .link_speed (link_speed),
    .time_ns    (time_ns),
    .run_en     (run_en),
    .inc_active (inc_active)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        link_apply = 1'b0;
    logic [1:0]  link_speed = '0;
    logic [63:0] time_ns;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ptp_tod_counter dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .link_apply (link_apply),
        .link_speed (link_speed),
        .time_ns    (time_ns)
    );

    function automatic logic [63:0] exp_time(input logic [63:0] v, input logic [39:0] inc, input int k);
        logic [63:0] prod;
        prod = 64'(k) * 64'(inc);
        return v + (prod >> 32);
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic [63:0] t_acc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        t_acc = time_ns;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 rsp_valid after read", 64'(rsp_valid), 64'd1);
        check("R9 ready low during response", 64'(req_ready), 64'd0);
        d = rsp_rdata;
    endtask

    task automatic load_time(input logic [63:0] v);
        bus_write(3'd2, v[31:0]);
        bus_write(3'd3, v[63:32]);
    endtask

    task automatic set_inc(input logic [39:0] inc);
        bus_write(3'd4, inc[31:0]);
        bus_write(3'd5, 32'(inc[39:32]));
    endtask

    task automatic pulse_link(input logic [1:0] spd);
        @(negedge clk);
        link_apply = 1'b1; link_speed = spd;
        @(negedge clk);
        link_apply = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t0, t1;
        logic [39:0] inc;
        logic [63:0] v;
        int k;
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 time after reset", time_ns, 64'd0);
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        bus_read(3'd4, d, t0);
        check("R1 reset increment fraction", 64'(d), 64'h9999_9999);
        bus_read(3'd5, d, t0);
        check("R1 reset increment integer", 64'(d), 64'h01);
        bus_read(3'd0, d, t0);
        check("R1 R10 enable A clear", 64'(d), 64'd0);
        check("R1 time still zero", time_ns, 64'd0);

        // R3 only one enable set
        load_time(64'h100);
        bus_write(3'd0, 32'h1);
        check("R9 no response to write", 64'(rsp_valid), 64'd0);
        repeat (10) @(negedge clk);
        check("R3 time holds with enable B clear", time_ns, 64'h100);
        bus_read(3'd0, d, t0);
        check("R10 enable A read", 64'(d), 64'd1);
        bus_read(3'd1, d, t0);
        check("R10 enable B read", 64'(d), 64'd0);
        bus_write(3'd1, 32'h1);
        bus_write(3'd0, 32'h0);
        repeat (10) @(negedge clk);
        t0 = time_ns;
        repeat (5) @(negedge clk);
        check("R3 time holds with enable A clear", time_ns, t0);
        bus_write(3'd0, 32'h1);

        // R2 R4 R6 random increments and loads while running
        for (int it = 0; it < 12; it++) begin
            if (it == 0)      inc = 40'h00_FFFF_FFFF;
            else if (it == 1) inc = 40'hFF_FFFF_FFFF;
            else if (it == 2) inc = 40'h00_0000_0001;
            else              inc = {8'($urandom()), 32'($urandom())};
            set_inc(inc);
            v = {1'b0, 31'($urandom()), 32'($urandom())};
            k = 1 + int'($urandom() % 40);
            load_time(v);
            check("R4 load overrides increment", time_ns, v);
            repeat (k) @(negedge clk);
            check("R2 time after k cycles", time_ns, exp_time(v, inc, k));
        end

        // R6 staging: low word alone changes nothing
        set_inc(40'h20_0000_0000);
        bus_write(3'd4, 32'h8000_0000);
        load_time(64'd0);
        repeat (10) @(negedge clk);
        check("R6 old increment until high word", time_ns, 64'd320);
        bus_read(3'd4, d, t0);
        check("R6 active fraction read", 64'(d), 64'd0);
        bus_read(3'd5, d, t0);
        check("R6 active integer read", 64'(d), 64'h20);
        bus_write(3'd5, 32'h1);
        load_time(64'd0);
        repeat (10) @(negedge clk);
        check("R6 committed increment 1.5ns", time_ns, 64'd15);

        // R5 coherent split read across a high-word change
        load_time(64'h0000_0003_FFFF_FF00);
        bus_read(3'd2, d, t0);
        check("R5 low word at accept", 64'(d), 64'(t0[31:0]));
        repeat (300) @(negedge clk);
        check("R2 high half advanced", 64'(time_ns[63:32]), 64'd4);
        bus_read(3'd3, d, t1);
        check("R5 high word is captured half", 64'(d), 64'(t0[63:32]));

        // R7 link-speed defaults
        for (int s = 0; s < 4; s++) begin
            logic [39:0] e;
            case (s)
                0: e = 40'h01_9999_9999;
                1: e = 40'h03_3333_3333;
                2: e = 40'h20_0000_0000;
                default: e = 40'h0;
            endcase
            pulse_link(2'(s));
            bus_read(3'd4, d, t0);
            check("R7 link default fraction", 64'(d), 64'(e[31:0]));
            bus_read(3'd5, d, t0);
            check("R7 link default integer", 64'(d), 64'(e[39:32]));
        end
        load_time(64'h55);
        repeat (10) @(negedge clk);
        check("R7 zero increment stops clock", time_ns, 64'h55);

        // R8 register commit beats link pulse in same cycle
        bus_write(3'd4, 32'h1234_5678);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd5; req_wdata = 32'h5;
        link_apply = 1'b1; link_speed = 2'd1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; link_apply = 1'b0;
        bus_read(3'd4, d, t0);
        check("R8 fraction from register", 64'(d), 64'h1234_5678);
        bus_read(3'd5, d, t0);
        check("R8 integer from register", 64'(d), 64'h5);
        load_time(64'h1000);
        repeat (7) @(negedge clk);
        check("R2 R8 time with winning increment", time_ns,
              exp_time(64'h1000, 40'h05_1234_5678, 7));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule